// File: doc/BRIEF.md
# Hardware Loop Counter Stack

This block keeps the iteration counts for the nested zero-overhead loops of a processor sequencer. Loop counts sit on a six-entry stack. The top entry is the live count of the loop that is running. A separate staging register holds the count for the next loop, so software can prepare an inner loop's count while the outer loop's count stays live on top of the stack. A push copies the staging value onto the stack and moves each older entry down one level.

The sequencer signals the termination test point of each iteration with `dec_i`. This point falls two instructions before the loop ends. At that point, if the live count is 1, the block raises `term_o` in the same cycle and pops the stack. Otherwise it decrements the live count, so a read late in an iteration already shows the next iteration's count. Software reaches both the live count and the staging register through a small register read/write port. The block reports the stack as full or empty. It also keeps a sticky overflow flag, which software clears.

Top module: `loopcnt_stack`

## Requirements
- R1: The stack holds 6 entries: `full_o` is 1 exactly when 6 entries are occupied, and `empty_o` is 1 exactly when none are.
- R2: A push (`push_i`) places the staging value on top and moves each older entry one level down, so later pops show the entries in last-in, first-out order.
- R3: A push while the stack is full sets `ovf_o` and leaves all six stored entries, including the top, unchanged.
- R4: `ovf_o` stays 1 through any later activity until `clr_ovf_i` is pulsed. If a push on a full stack and `clr_ovf_i` arrive in the same cycle, the flag ends up set.
- R5: `empty_o` follows the occupancy from cycle to cycle. Any push clears it, and removing the last entry sets it again.
- R6: A pop on an empty stack changes nothing and sets no flag.
- R7: With `rd_sel_i`=0, `rd_data_o` gives the live count, or 0xFFFFFFFF when the stack is empty. A write with `wr_sel_i`=0 replaces the live count when the stack is not empty and is ignored when it is empty.
- R8: With `rd_sel_i`=1 / `wr_sel_i`=1, `rd_data_o` / a write access the staging register. Writing the staging register never changes the live count.
- R9: When `dec_i` is high, the stack is not empty and the live count is not 1, the live count becomes one lower on the next cycle and `term_o` stays 0.
- R10: When `dec_i` is high and the live count is 1, `term_o` is 1 in that same cycle and the stack pops, so the next entry down becomes the live count.
- R11: `dec_i` on an empty stack has no effect and `term_o` stays 0.
- R12: When several requests arrive in one cycle, push wins over pop, pop wins over `dec_i`, and `dec_i` wins over a live-count write.
- R13: A synchronous `rst` empties the stack, clears `ovf_o` and sets the staging register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push the staging value |
| pop_i | input | 1 | Pop the stack |
| dec_i | input | 1 | Termination test point of the running loop |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 live count, 1 staging |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read source: 0 live count, 1 staging |
| rd_data_o | output | 32 | Read data |
| clr_ovf_i | input | 1 | Clear the sticky overflow flag |
| term_o | output | 1 | Loop terminates at this test point |
| full_o | output | 1 | All entries occupied |
| empty_o | output | 1 | No entries occupied |
| ovf_o | output | 1 | Sticky overflow |

## Verification
The hardest case to reach from the ports is a termination inside a nested loop. There, the pop has to bring the outer loop's count back as the live value while the inner loop's final test point raises `term_o`. The bench first pushes an outer count. It then sweeps the inner count over 1 to 8 and issues exactly that many test points. At each one it checks `term_o` before the clock edge and the read-back count after it. At the end it expects the outer count on top, unchanged. A full-stack push arriving in the same cycle as a flag clear is also set up on purpose, to test the set-over-clear rule.

// File: rtl/loopcnt_pkg.sv
package loopcnt_pkg;

    // Operation applied to the stack storage in one cycle
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_LOAD = 2'd3
    } stk_op_e;

    localparam logic SEL_CUR   = 1'b0;
    localparam logic SEL_STAGE = 1'b1;

endpackage

// File: rtl/loopcnt_store.sv
module loopcnt_store
    import loopcnt_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int W     = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  stk_op_e                          op,
    input  logic [W-1:0]                     push_val,
    input  logic [W-1:0]                     load_val,
    output logic [W-1:0]                     top_o,
    output logic [$clog2(DEPTH+1)-1:0]       lvl_o,
    output logic                             full_o,
    output logic                             empty_o
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [LVL_W-1:0]        lvl;
    } store_t;

    store_t st_d, st_q;
    logic [W-1:0] ent_nx [DEPTH];
    logic full_w, empty_w;

    assign full_w  = (st_q.lvl == LVL_MAX);
    assign empty_w = (st_q.lvl == '0);

    // Per-slot next value: shift down on push, shift up on pop
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] above, below;
        if (i == 0) begin : g_first
            assign above = push_val;
        end else begin : g_mid
            assign above = st_q.ent[i-1];
        end
        if (i == DEPTH - 1) begin : g_last
            assign below = '0;
        end else begin : g_inner
            assign below = st_q.ent[i+1];
        end
        always_comb begin
            ent_nx[i] = st_q.ent[i];
            unique case (op)
                OP_PUSH: if (!full_w)  ent_nx[i] = above;
                OP_POP:  if (!empty_w) ent_nx[i] = below;
                OP_LOAD: if (!empty_w && i == 0) ent_nx[i] = load_val;
                default: ent_nx[i] = st_q.ent[i];
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < DEPTH; k++) begin
            st_d.ent[k] = ent_nx[k];
        end
        if (op == OP_PUSH && !full_w) begin
            st_d.lvl = st_q.lvl + 1'b1;
        end else if (op == OP_POP && !empty_w) begin
            st_d.lvl = st_q.lvl - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top_o   = st_q.ent[0];
    assign lvl_o   = st_q.lvl;
    assign full_o  = full_w;
    assign empty_o = empty_w;

    // R1: occupancy never exceeds the stack depth
    a_r1_level_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.lvl <= LVL_MAX);

    // R3: a push on a full stack keeps the top entry and stays full
    a_r3_full_push_keeps: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH && full_w) |=> (full_o && top_o == $past(top_o)));

    // R6: a pop on an empty stack leaves it empty
    a_r6_pop_empty_noop: assert property (@(posedge clk) disable iff (rst)
        (op == OP_POP && empty_w) |=> empty_o);

endmodule

// File: rtl/loopcnt_flags.sv
module loopcnt_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic ovf_o
);
    typedef struct packed {
        logic ovf;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr_i) fl_d.ovf = 1'b0;
        if (set_i) fl_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign ovf_o = fl_q.ovf;

    // R4: the flag holds until an explicit clear
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !clr_i) |=> ovf_o);

    // R3: an overflow event is always recorded
    a_r3_ovf_set: assert property (@(posedge clk) disable iff (rst)
        set_i |=> ovf_o);

endmodule

// File: rtl/loopcnt_ctrl.sv
module loopcnt_ctrl
    import loopcnt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          dec_i,
    input  logic          cur_wr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic [W-1:0]  top_i,
    input  logic          empty_i,
    output stk_op_e       op_o,
    output logic [W-1:0]  load_val_o,
    output logic          term_o
);
    localparam logic [W-1:0] LAST_CNT = W'(1);

    logic at_last;
    assign at_last = (top_i == LAST_CNT);

    // Fixed priority: push, pop, test point, live-count write
    always_comb begin
        op_o       = OP_NONE;
        load_val_o = wr_data_i;
        term_o     = 1'b0;
        if (push_i) begin
            op_o = OP_PUSH;
        end else if (pop_i) begin
            op_o = OP_POP;
        end else if (dec_i && !empty_i) begin
            if (at_last) begin
                op_o   = OP_POP;
                term_o = 1'b1;
            end else begin
                op_o       = OP_LOAD;
                load_val_o = top_i - 1'b1;
            end
        end else if (cur_wr_i && !empty_i) begin
            op_o = OP_LOAD;
        end
    end

endmodule

// File: rtl/loopcnt_stack.sv
module loopcnt_stack
    import loopcnt_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int W     = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          dec_i,
    input  logic          wr_en_i,
    input  logic          wr_sel_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic          rd_sel_i,
    output logic [W-1:0]  rd_data_o,
    input  logic          clr_ovf_i,
    output logic          term_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          ovf_o
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [W-1:0] stage;
    } regs_t;

    regs_t rg_d, rg_q;
    stk_op_e op_w;
    logic [W-1:0] load_w, top_w;
    logic [LVL_W-1:0] lvl_w;
    logic full_w, empty_w, cur_wr_w;

    assign cur_wr_w = wr_en_i && (wr_sel_i == SEL_CUR);

    always_comb begin
        rg_d = rg_q;
        if (wr_en_i && wr_sel_i == SEL_STAGE) rg_d.stage = wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    loopcnt_ctrl #(.W(W)) u_ctrl (
        .push_i     (push_i),
        .pop_i      (pop_i),
        .dec_i      (dec_i),
        .cur_wr_i   (cur_wr_w),
        .wr_data_i  (wr_data_i),
        .top_i      (top_w),
        .empty_i    (empty_w),
        .op_o       (op_w),
        .load_val_o (load_w),
        .term_o     (term_o)
    );

    loopcnt_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .op       (op_w),
        .push_val (rg_q.stage),
        .load_val (load_w),
        .top_o    (top_w),
        .lvl_o    (lvl_w),
        .full_o   (full_w),
        .empty_o  (empty_w)
    );

    loopcnt_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (op_w == OP_PUSH && full_w),
        .clr_i (clr_ovf_i),
        .ovf_o (ovf_o)
    );

    always_comb begin
        if (rd_sel_i == SEL_STAGE) begin
            rd_data_o = rg_q.stage;
        end else if (empty_w) begin
            rd_data_o = '1;
        end else begin
            rd_data_o = top_w;
        end
    end

    assign full_o  = full_w;
    assign empty_o = empty_w;

    // R5: any push leaves the stack non-empty
    a_r5_push_clears_empty: assert property (@(posedge clk) disable iff (rst)
        push_i |=> !empty_o);

    // R10: a termination removes exactly one entry
    a_r10_term_pops: assert property (@(posedge clk) disable iff (rst)
        term_o |=> (lvl_w == $past(lvl_w) - 1'b1));

    // R9: an ordinary test point lowers the live count by one
    a_r9_dec_step: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !push_i && !pop_i && !empty_w && !term_o)
            |=> (top_w == $past(top_w) - 1'b1));

    // R11: a test point on an empty stack never terminates
    a_r11_empty_no_term: assert property (@(posedge clk) disable iff (rst)
        (dec_i && empty_w) |-> !term_o);

endmodule

// File: tb/loopcnt_stack_test.sv
`timescale 1ns/1ps
module loopcnt_stack_test;
    logic clk = 1'b0;
    logic rst;
    logic push_i, pop_i, dec_i, wr_en_i, wr_sel_i, rd_sel_i, clr_ovf_i;
    logic [31:0] wr_data_i, rd_data_o;
    logic term_o, full_o, empty_o, ovf_o;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    loopcnt_stack uut (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .dec_i(dec_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .clr_ovf_i(clr_ovf_i),
        .term_o(term_o), .full_o(full_o), .empty_o(empty_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        push_i = 0; pop_i = 0; dec_i = 0; wr_en_i = 0; clr_ovf_i = 0; rst = 0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        rd_sel_i = sel;
        #0.5;
        v = rd_data_o;
    endtask

    task automatic wr(input logic sel, input logic [31:0] v);
        wr_en_i = 1; wr_sel_i = sel; wr_data_i = v;
        tick();
    endtask

    task automatic push_val(input logic [31:0] v);
        wr(1'b1, v);
        push_i = 1;
        tick();
    endtask

    task automatic drain();
        for (int k = 0; k < 8; k++) begin
            pop_i = 1;
            tick();
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int lvl;
        rst = 1; push_i = 0; pop_i = 0; dec_i = 0; wr_en_i = 0; wr_sel_i = 0;
        rd_sel_i = 0; clr_ovf_i = 0; wr_data_i = 0;
        tick(); rst = 1; tick();

        // R13 / R1: reset state
        chk("R13 empty", {31'd0, empty_o}, 1);
        chk("R1 full", {31'd0, full_o}, 0);
        chk("R13 ovf", {31'd0, ovf_o}, 0);
        rd(0, v); chk("R7 empty read", v, 32'hFFFF_FFFF);
        rd(1, v); chk("R13 stage", v, 0);

        // R1 R2 R3 R5: fill sweep beyond depth
        lvl = 0;
        for (int k = 1; k <= 8; k++) begin
            push_val(32'h100 + k);
            lvl = (lvl < 6) ? lvl + 1 : 6;
            chk("R5 push clears empty", {31'd0, empty_o}, 0);
            chk("R1 full flag", {31'd0, full_o}, (lvl == 6) ? 1 : 0);
            chk("R3 ovf flag", {31'd0, ovf_o}, (k > 6) ? 1 : 0);
            rd(0, v); chk("R3 top kept", v, 32'h100 + ((k > 6) ? 6 : k));
        end
        // R8: staging write leaves live count alone
        wr(1'b1, 32'hDEAD_BEEF);
        rd(0, v); chk("R8 cur unchanged", v, 32'h106);
        rd(1, v); chk("R8 stage read", v, 32'hDEAD_BEEF);

        // R4: sticky through pops, then cleared; set wins over clear
        pop_i = 1; tick(); pop_i = 1; tick();
        chk("R4 sticky", {31'd0, ovf_o}, 1);
        clr_ovf_i = 1; tick();
        chk("R4 clear", {31'd0, ovf_o}, 0);
        push_val(32'h105); push_val(32'h106);
        push_i = 1; clr_ovf_i = 1; tick();
        chk("R4 set wins", {31'd0, ovf_o}, 1);
        clr_ovf_i = 1; tick();

        // R2: LIFO order on pops
        for (int k = 6; k >= 1; k--) begin
            rd(0, v); chk("R2 lifo", v, 32'h100 + k);
            chk("R1 not empty", {31'd0, empty_o}, 0);
            pop_i = 1; tick();
        end
        chk("R5 empty again", {31'd0, empty_o}, 1);

        // R6: pop on empty
        pop_i = 1; tick();
        chk("R6 empty", {31'd0, empty_o}, 1);
        chk("R6 ovf", {31'd0, ovf_o}, 0);
        rd(0, v); chk("R6 read", v, 32'hFFFF_FFFF);

        // R7: live-count write on empty ignored, then applied
        wr(1'b0, 32'h5);
        rd(0, v); chk("R7 write ignored", v, 32'hFFFF_FFFF);
        chk("R7 still empty", {31'd0, empty_o}, 1);
        push_val(32'h7);
        wr(1'b0, 32'h9);
        rd(0, v); chk("R7 write applied", v, 32'h9);
        drain();

        // R11: test point on empty
        dec_i = 1; #0.5;
        chk("R11 no term", {31'd0, term_o}, 0);
        tick();
        chk("R11 empty", {31'd0, empty_o}, 1);

        // R9 R10: nested loop sweep, inner count 1..8 under outer 50
        for (int n = 1; n <= 8; n++) begin
            push_val(32'd50);
            push_val(n);
            for (int it = n; it >= 1; it--) begin
                rd(0, v); chk("R9 count", v, it);
                dec_i = 1; #0.5;
                chk("R10 term", {31'd0, term_o}, (it == 1) ? 1 : 0);
                tick();
            end
            rd(0, v); chk("R10 outer restored", v, 32'd50);
            pop_i = 1; tick();
            chk("R10 drained", {31'd0, empty_o}, 1);
        end

        // R12: priorities
        push_val(32'd4);
        wr(1'b1, 32'd8);
        push_i = 1; pop_i = 1; tick();
        rd(0, v); chk("R12 push over pop", v, 32'd8);
        pop_i = 1; dec_i = 1; tick();
        rd(0, v); chk("R12 pop over dec", v, 32'd4);
        dec_i = 1; wr_en_i = 1; wr_sel_i = 0; wr_data_i = 32'd77; tick();
        rd(0, v); chk("R12 dec over write", v, 32'd3);

        // R13: reset mid-state
        push_val(1); push_val(2); push_val(3); push_val(4); push_val(5);
        chk("R13 pre full", {31'd0, full_o}, 1);
        push_i = 1; tick();
        rst = 1; tick();
        chk("R13 empty after", {31'd0, empty_o}, 1);
        chk("R13 ovf after", {31'd0, ovf_o}, 0);
        rd(1, v); chk("R13 stage after", v, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule